// File: doc/BRIEF.md
# Cascadable Up/Down Counter

A presettable counter that counts either up or down on the rising clock edge. A parameter sets the modulus. A value of 10 gives a decade stage (0 to 9). A value of 16 gives a binary stage (0 to 15). Both variants have the same pins. The counter takes a parallel value through an active-low synchronous load. It advances only when two active-low enables are both asserted. The level of the direction pin picks up or down.

An active-low carry output reports that the stage sits at the last value for its current direction. This output is gated by the second enable only. To build a wider synchronous counter, feed each stage's carry into the next stage's gating enable and give all stages one shared clock. The carry is combinational, so the chain settles within the cycle and every stage steps on the same edge.

Top module: `sync_updn_counter`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0, without waiting for a clock edge.
- R2: When `load_ni` is low at a rising edge, `q_o` takes `data_i` on that edge. The enables and `up_i` are ignored for that edge.
- R3: When `load_ni` is high and either `en_p_ni` or `en_t_ni` is high at an edge, `q_o` keeps its value.
- R4: With `load_ni` high, both enables low and `up_i` = 1, `q_o` increments on each edge. It wraps from MODULUS-1 to 0.
- R5: With `load_ni` high, both enables low and `up_i` = 0, `q_o` decrements on each edge. It wraps from 0 to MODULUS-1.
- R6: `carry_no` is 0 exactly when `en_t_ni` is 0 and one of two conditions holds: `up_i` = 1 and `q_o` = MODULUS-1, or `up_i` = 0 and `q_o` = 0. It follows changes on `en_t_ni` and `up_i` within the same cycle.
- R7: In decade mode, a loaded value of 10 to 15 steps to 0 when counting up and to one less when counting down. `carry_no` stays 1 for such a value.
- R8: A change on `load_ni`, `data_i`, the enables or `up_i` between edges leaves `q_o` unchanged until the next rising edge.
- R9: Two stages work as a chained counter when the low stage's `carry_no` drives the high stage's `en_t_ni` and both share the clock, load, `en_p_ni` and `up_i`. The combined value then counts modulo MODULUS² in both directions, for both moduli.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | W | Value to load |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| en_p_ni | input | 1 | Count enable, active low |
| en_t_ni | input | 1 | Count enable that also gates the carry, active low |
| q_o | output | W | Current count |
| carry_no | output | 1 | Terminal-value carry, active low |

## Verification
One stimulus pattern loads a value near the top and counts up through the wrap, inhibits for one edge, then counts down back through the wrap. It runs on a decade chain and a binary chain at once. This shows that the wrap point depends on the modulus and that the hold does not depend on direction. Carry checks switch `up_i` and `en_t_ni` between edges, which separates a combinational carry from a registered one. Out-of-range decade loads, load priority over counting, and inputs changed between edges each isolate one decode path. Multi-step chain runs across the combined top and bottom values are compared with an integer model and show that the high stage steps only on the low stage's terminal edge.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_UP   = 2'd2,
    OP_DN   = 2'd3
  } updn_op_e;
endpackage

// File: rtl/updn_next.sv
module updn_next
  import updn_pkg::*;
#(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TERM = 4'd9
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  input  updn_op_e     op_i,
  output logic [W-1:0] nxt_o
);
  always_comb begin
    unique case (op_i)
      OP_LOAD: nxt_o = d_i;
      // anything at or above TERM (incl. out-of-range decade codes) goes to 0
      OP_UP:   nxt_o = (q_i >= TERM) ? '0 : q_i + W'(1);
      OP_DN:   nxt_o = (q_i == '0) ? TERM : q_i - W'(1);
      default: nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TERM = 4'd9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] q_i,
  input  logic         up_i,
  input  logic         en_t_ni,
  output logic         carry_no
);
  logic at_end;

  assign at_end   = up_i ? (q_i == TERM) : (q_i == '0);
  assign carry_no = ~(~en_t_ni & at_end);

  // R6
  carry_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_t_ni |-> carry_no);
endmodule

// File: rtl/sync_updn_counter.sv
module sync_updn_counter
  import updn_pkg::*;
#(
  parameter int unsigned MODULUS = 10,
  parameter int unsigned W = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         up_i,
  input  logic         en_p_ni,
  input  logic         en_t_ni,
  output logic [W-1:0] q_o,
  output logic         carry_no
);
  localparam logic [W-1:0] TERM = W'(MODULUS - 1);

  updn_op_e     op;
  logic [W-1:0] nxt;

  // load wins over counting
  always_comb begin
    if (!load_ni)                  op = OP_LOAD;
    else if (!en_p_ni && !en_t_ni) op = up_i ? OP_UP : OP_DN;
    else                           op = OP_HOLD;
  end

  updn_next #(.W(W), .TERM(TERM)) u_next (
    .q_i  (q_o),
    .d_i  (data_i),
    .op_i (op),
    .nxt_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end

  updn_term #(.W(W), .TERM(TERM)) u_term (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .q_i     (q_o),
    .up_i    (up_i),
    .en_t_ni (en_t_ni),
    .carry_no(carry_no)
  );

  // R2
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(data_i));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (en_p_ni || en_t_ni)) |=> $stable(q_o));

  // R4
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && up_i && q_o == TERM) |=> q_o == '0);

  // R5
  dn_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_p_ni && !en_t_ni && !up_i && q_o == '0) |=> q_o == TERM);
endmodule

// File: tb/sync_updn_counter_tb_top.sv
`timescale 1ns/1ps
module sync_updn_counter_tb_top;
  logic clk = 1'b0;
  logic rst_ni;
  logic ln, up, ep, et;
  logic [3:0] dd_lo, dd_hi, db_lo, db_hi;
  logic [3:0] qd_lo, qd_hi, qb_lo, qb_hi;
  logic cd_lo, cd_hi, cb_lo, cb_hi;
  int nchk = 0, nfail = 0;
  int tot_d, tot_b;
  bit vd, vb;

  always #2.5 clk = ~clk;

  sync_updn_counter #(.MODULUS(10)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(ln), .data_i(dd_lo), .up_i(up),
    .en_p_ni(ep), .en_t_ni(et), .q_o(qd_lo), .carry_no(cd_lo));
  sync_updn_counter #(.MODULUS(10)) u_dec_hi (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(ln), .data_i(dd_hi), .up_i(up),
    .en_p_ni(ep), .en_t_ni(cd_lo), .q_o(qd_hi), .carry_no(cd_hi));
  sync_updn_counter #(.MODULUS(16)) u_bin_lo (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(ln), .data_i(db_lo), .up_i(up),
    .en_p_ni(ep), .en_t_ni(et), .q_o(qb_lo), .carry_no(cb_lo));
  sync_updn_counter #(.MODULUS(16)) u_bin_hi (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(ln), .data_i(db_hi), .up_i(up),
    .en_p_ni(ep), .en_t_ni(cb_lo), .q_o(qb_hi), .carry_no(cb_hi));

  // {load_n, dec data, bin data, up, en_p, en_t, exp dec, exp bin}
  localparam logic [19:0] VEC [12] = '{
    {1'b0, 4'd7, 4'd13, 1'b1, 1'b0, 1'b0, 4'd7,  4'd13},
    {1'b1, 4'd0, 4'd0,  1'b1, 1'b0, 1'b0, 4'd8,  4'd14},
    {1'b1, 4'd0, 4'd0,  1'b1, 1'b0, 1'b0, 4'd9,  4'd15},
    {1'b1, 4'd0, 4'd0,  1'b1, 1'b0, 1'b0, 4'd0,  4'd0},
    {1'b1, 4'd0, 4'd0,  1'b1, 1'b0, 1'b0, 4'd1,  4'd1},
    {1'b1, 4'd0, 4'd0,  1'b1, 1'b0, 1'b0, 4'd2,  4'd2},
    {1'b1, 4'd0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd2,  4'd2},
    {1'b1, 4'd0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd1,  4'd1},
    {1'b1, 4'd0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  4'd0},
    {1'b1, 4'd0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd9,  4'd15},
    {1'b1, 4'd0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd8,  4'd14},
    {1'b1, 4'd0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd7,  4'd13}
  };

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int exp_cy(input int q, input int term, input bit u, input bit t);
    return (!t && (u ? q == term : q == 0)) ? 0 : 1;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // drives at negedge, clocks once, checks chain against the integer model
  task automatic tick(input bit l, input logic [3:0] a, b, c, d,
                      input bit u, p, t);
    ln = l; dd_lo = a; dd_hi = b; db_lo = c; db_hi = d; up = u; ep = p; et = t;
    if (!l) begin
      tot_d = b * 10 + a; vd = (a < 10) && (b < 10);
      tot_b = d * 16 + c; vb = 1'b1;
    end else if (!p && !t) begin
      tot_d = u ? (tot_d + 1) % 100 : (tot_d + 99) % 100;
      tot_b = u ? (tot_b + 1) % 256 : (tot_b + 255) % 256;
    end
    @(posedge clk); @(negedge clk);
    if (vd) begin
      chk("R9 dec lo", qd_lo, tot_d % 10);
      chk("R9 dec hi", qd_hi, tot_d / 10);
      chk("R6 dec carry", cd_lo, exp_cy(qd_lo, 9, up, et));
    end
    if (vb) begin
      chk("R9 bin lo", qb_lo, tot_b % 16);
      chk("R9 bin hi", qb_hi, tot_b / 16);
      chk("R6 bin carry", cb_lo, exp_cy(qb_lo, 15, up, et));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; ln = 1'b1; up = 1'b1; ep = 1'b1; et = 1'b1;
    dd_lo = 4'd0; dd_hi = 4'd0; db_lo = 4'd0; db_hi = 4'd0;
    tot_d = 0; tot_b = 0; vd = 1'b0; vb = 1'b0;
    #7;
    // R1 reset state
    chk("R1 dec", qd_lo, 0); chk("R1 bin", qb_lo, 0);
    chk("R1 chain", qd_hi + qb_hi, 0);
    @(negedge clk); rst_ni = 1'b1;

    // reference sequence on both chains
    for (int i = 0; i < 12; i++) begin
      logic [19:0] v;
      string rq;
      v = VEC[i];
      rq = !v[19] ? "R2" : (v[9] ? "R3" : (v[10] ? "R4" : "R5"));
      tick(v[19], v[18:15], 4'd0, v[14:11], 4'd0, v[10], v[9], v[8]);
      chk(rq, qd_lo, v[7:4]);
      chk(rq, qb_lo, v[3:0]);
    end

    // R6 carry is combinational on up_i and en_t_ni
    tick(1'b0, 4'd9, 4'd0, 4'd15, 4'd0, 1'b1, 1'b1, 1'b0);
    chk("R6 up term dec", cd_lo, 0); chk("R6 up term bin", cb_lo, 0);
    up = 1'b0; #1;
    chk("R6 dir flip dec", cd_lo, 1); chk("R6 dir flip bin", cb_lo, 1);
    tick(1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0);
    chk("R6 dn term", cd_lo, 0);
    et = 1'b1; #1;
    chk("R6 T gate", cd_lo, 1); chk("R6 T gate bin", cb_lo, 1);

    // R2 load priority over active count
    tick(1'b0, 4'd4, 4'd3, 4'd6, 4'd5, 1'b1, 1'b0, 1'b0);
    chk("R2 priority", qd_lo, 4);

    // R8 mid-cycle changes
    ln = 1'b0; dd_lo = 4'd8; up = 1'b0; ep = 1'b0; et = 1'b0; #1;
    chk("R8 mid-cycle", qd_lo, 4);
    ln = 1'b1; ep = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 after edge", qd_lo, 4);

    // R7 out-of-range decade values
    tick(1'b0, 4'd12, 4'd0, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0);
    chk("R7 load", qd_lo, 12); chk("R7 carry up", cd_lo, 1);
    up = 1'b0; #1; chk("R7 carry dn", cd_lo, 1);
    vd = 1'b0;
    ln = 1'b1; up = 1'b1; ep = 1'b0; et = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 up to 0", qd_lo, 0);
    tick(1'b0, 4'd12, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b1);
    vd = 1'b0;
    ln = 1'b1; up = 1'b0; ep = 1'b0; et = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 dn by one", qd_lo, 11);

    // R9 chained rollover both ways, both moduli
    tick(1'b0, 4'd7, 4'd9, 4'd13, 4'd15, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 0, 0, 0, 0, 1'b1, 1'b0, 1'b0);
    tick(1'b0, 4'd2, 4'd0, 4'd2, 4'd0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 4'd1, 4'd5, 4'd0, 4'd7, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    chk("R9 mid borrow", qd_hi, 4);

    finish_run();
  end
endmodule